// File: doc/BRIEF.md
# Lane-Relative Masked Population Counter

This unit produces bit-count results for one lane of a 64-lane SIMD wave. Each request carries an operation code, two 32-bit operands, the index of the executing lane and a valid strobe. The unit counts the set bits of the first operand, adds the count to the second operand, and returns the registered sum one cycle later together with an output valid strobe.

Three counting operations exist. The plain count uses every bit of the first operand. The two lane-relative variants count only the bits that belong to lanes strictly below the executing lane. One variant covers the lower 32 lanes and the other the upper 32. The second operand is an addend, so the lower-half result of a 64-bit lane mask can be fed in as the addend of the upper-half operation. The pair then yields the number of set mask bits below the lane across the whole wave. Each operation is accepted under a short code and under an extended code that is 256 higher. Any other code yields a zero result and raises an illegal-operation flag.

The output side is a three-state machine. ST_IDLE means no result is presented. ST_RESULT means a legal result is presented. ST_ILLEGAL means a rejected request is being reported. Every state moves the same way on each clock. A valid request with a legal code goes to ST_RESULT. A valid request with an unknown code goes to ST_ILLEGAL. A cycle with no valid request goes to ST_IDLE.

Top module: `lane_popcnt_unit`

## Requirements
- R1: While reset is held and right after it is released, out_valid and out_illegal are 0 and out_result is 0.
- R2: Opcode 34 returns in_src_b plus the number of ones in all 32 bits of in_src_a. The lane index has no effect on the result.
- R3: Opcode 35 with in_lane below 32 returns in_src_b plus the number of ones in in_src_a bits 0 to in_lane-1. With in_lane 0 the result is in_src_b.
- R4: Opcode 35 with in_lane of 32 or more counts all 32 bits of in_src_a.
- R5: Opcode 36 with in_lane of 32 or more returns in_src_b plus the number of ones in in_src_a bits 0 to in_lane-33.
- R6: Opcode 36 with in_lane below 32 returns exactly in_src_b.
- R7: Opcodes 290, 291 and 292 behave exactly like 34, 35 and 36.
- R8: The addition wraps modulo 2^32.
- R9: out_valid is high exactly in the cycle after a cycle with in_valid high, and out_result is updated in that same cycle.
- R10: Any other opcode gives out_result 0 with out_valid and out_illegal both high for that one cycle. out_illegal falls when the next output is legal or absent.
- R11: While in_valid is low, out_result keeps its last value whatever the other inputs do.
- R12: Take a 64-bit lane mask. A lower-half operation on its low word with addend 0, then an upper-half operation on its high word with the first result as addend, gives the number of mask bits strictly below the lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_opcode | input | 9 | Operation code |
| in_src_a | input | 32 | Word whose bits are counted |
| in_src_b | input | 32 | Addend |
| in_lane | input | 6 | Index of the executing lane (0 to 63) |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 32 | Registered sum |
| out_illegal | output | 1 | High with out_valid when the opcode was not recognised |

## Verification
Two outputs can meet at one clock edge. A rejected request can be followed at once by a legal one, and a legal one by a rejected one. In each case the output machine leaves one of its presenting states for the other, and the illegal flag and the result register must change together. The bench issues these requests back to back with no idle cycle between them. It checks that out_illegal is high only in the cycle that belongs to the bad code, and that the next cycle carries the correct count with the flag low.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    typedef enum logic [1:0] {
        OPK_NONE,
        OPK_FULL,
        OPK_LOW,
        OPK_HIGH
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RESULT,
        ST_ILLEGAL
    } out_state_e;

endpackage

// File: rtl/lpc_decode.sv
module lpc_decode
    import lpc_pkg::*;
#(
    parameter int OPC_W    = 9,
    parameter int OPC_BASE = 34,
    parameter int OPC_EXT  = 256
) (
    input  logic [OPC_W-1:0] opcode,
    output op_kind_e         kind
);
    localparam logic [OPC_W-1:0] C_FULL   = OPC_W'(OPC_BASE);
    localparam logic [OPC_W-1:0] C_LOW    = OPC_W'(OPC_BASE + 1);
    localparam logic [OPC_W-1:0] C_HIGH   = OPC_W'(OPC_BASE + 2);
    localparam logic [OPC_W-1:0] C_FULL_X = OPC_W'(OPC_BASE + OPC_EXT);
    localparam logic [OPC_W-1:0] C_LOW_X  = OPC_W'(OPC_BASE + OPC_EXT + 1);
    localparam logic [OPC_W-1:0] C_HIGH_X = OPC_W'(OPC_BASE + OPC_EXT + 2);

    always_comb begin
        kind = OPK_NONE;
        if (opcode == C_FULL || opcode == C_FULL_X) begin
            kind = OPK_FULL;
        end else if (opcode == C_LOW || opcode == C_LOW_X) begin
            kind = OPK_LOW;
        end else if (opcode == C_HIGH || opcode == C_HIGH_X) begin
            kind = OPK_HIGH;
        end
    end

endmodule

// File: rtl/lpc_mask_gen.sv
module lpc_mask_gen
    import lpc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 6
) (
    input  op_kind_e          kind,
    input  logic [LANE_W-1:0] lane,
    output logic [DATA_W-1:0] mask
);
    // Bit i of the mask is set when the lane it stands for lies below the
    // executing lane; the upper half shifts every position by DATA_W lanes.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        localparam int LO_POS = i;
        localparam int HI_POS = i + DATA_W;
        logic below_lo;
        logic below_hi;
        assign below_lo = int'(lane) > LO_POS;
        assign below_hi = int'(lane) > HI_POS;
        assign mask[i]  = (kind == OPK_FULL)
                        | ((kind == OPK_LOW)  & below_lo)
                        | ((kind == OPK_HIGH) & below_hi);
    end

endmodule

// File: rtl/lpc_popcount.sv
module lpc_popcount #(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] word,
    output logic [CNT_W-1:0]  count
);
    always_comb begin
        count = '0;
        for (int k = 0; k < DATA_W; k++) begin
            count = count + CNT_W'(word[k]);
        end
    end

endmodule

// File: rtl/lane_popcnt_unit.sv
module lane_popcnt_unit
    import lpc_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int LANE_W   = 6,
    parameter int OPC_W    = 9,
    parameter int OPC_BASE = 34,
    parameter int OPC_EXT  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OPC_W-1:0]  in_opcode,
    input  logic [DATA_W-1:0] in_src_a,
    input  logic [DATA_W-1:0] in_src_b,
    input  logic [LANE_W-1:0] in_lane,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_illegal
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    op_kind_e          kind;
    logic [DATA_W-1:0] lane_mask;
    logic [CNT_W-1:0]  bit_count;
    logic [DATA_W-1:0] sum;
    logic              legal;
    out_state_e        state_q;
    out_state_e        state_d;
    logic [DATA_W-1:0] result_q;

    lpc_decode #(
        .OPC_W    (OPC_W),
        .OPC_BASE (OPC_BASE),
        .OPC_EXT  (OPC_EXT)
    ) u_decode (
        .opcode (in_opcode),
        .kind   (kind)
    );

    lpc_mask_gen #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_mask (
        .kind (kind),
        .lane (in_lane),
        .mask (lane_mask)
    );

    lpc_popcount #(
        .DATA_W (DATA_W)
    ) u_count (
        .word  (in_src_a & lane_mask),
        .count (bit_count)
    );

    assign legal = (kind != OPK_NONE);
    assign sum   = in_src_b + DATA_W'(bit_count);

    // Next-state logic: every state follows the same request-driven arcs.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_RESULT, ST_ILLEGAL: begin
                if (!in_valid) begin
                    state_d = ST_IDLE;
                end else if (legal) begin
                    state_d = ST_RESULT;
                end else begin
                    state_d = ST_ILLEGAL;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (in_valid) begin
            result_q <= legal ? sum : '0;
        end
    end

    // Output decode from the state register.
    always_comb begin
        out_valid   = 1'b0;
        out_illegal = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                out_valid   = 1'b0;
                out_illegal = 1'b0;
            end
            ST_RESULT: begin
                out_valid   = 1'b1;
                out_illegal = 1'b0;
            end
            ST_ILLEGAL: begin
                out_valid   = 1'b1;
                out_illegal = 1'b1;
            end
            default: begin
                out_valid   = 1'b0;
                out_illegal = 1'b0;
            end
        endcase
    end

    assign out_result = result_q;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R9
    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_valid && out_result == '0)); // R10
    AST_ILLEGAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_illegal && (!in_valid || legal)) |=> !out_illegal); // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result)); // R11
    AST_HIGH_BELOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == OPK_HIGH && int'(in_lane) < DATA_W)
        |=> out_result == $past(in_src_b)); // R6

endmodule

// File: tb/lane_popcnt_unit_bench.sv
module lane_popcnt_unit_bench;

    localparam time CLK_PER = 8ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [8:0]  in_opcode = '0;
    logic [31:0] in_src_a = '0;
    logic [31:0] in_src_b = '0;
    logic [5:0]  in_lane = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_illegal;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 0;

    always #(CLK_PER/2) clk = ~clk;

    lane_popcnt_unit u_lane_popcnt_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_opcode   (in_opcode),
        .in_src_a    (in_src_a),
        .in_src_b    (in_src_b),
        .in_lane     (in_lane),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_illegal (out_illegal)
    );

    function automatic logic [31:0] model(input int op, input logic [31:0] a,
                                          input logic [31:0] b, input int lane);
        int n = 0;
        case (op)
            34, 290: for (int k = 0; k < 32; k++) n += a[k];
            35, 291: for (int k = 0; k < 32; k++) if (k < lane) n += a[k];
            36, 292: for (int k = 0; k < 32; k++) if (k + 32 < lane) n += a[k];
            default: return 32'h0;
        endcase
        return b + 32'(n);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Present one request; sample the registered output after the next edge.
    task automatic issue(input string tag, input int op, input logic [31:0] a,
                         input logic [31:0] b, input int lane);
        @(negedge clk);
        in_valid  = 1'b1;
        in_opcode = 9'(op);
        in_src_a  = a;
        in_src_b  = b;
        in_lane   = 6'(lane);
        @(posedge clk);
        #2;
        chk({tag, " result"}, out_result, model(op, a, b, lane));
        chk({tag, " valid"}, 32'(out_valid), 32'd1);
        chk({tag, " illegal"}, 32'(out_illegal),
            32'((op % 256 < 34) || (op % 256 > 36) || op > 292));
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(posedge clk);
        #2;
        chk("R1 valid in reset", 32'(out_valid), 32'd0);
        chk("R1 result in reset", out_result, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        chk("R1 illegal after reset", 32'(out_illegal), 32'd0);
        chk("R1 valid after reset", 32'(out_valid), 32'd0);
    endtask

    task automatic t_plain();
        issue("R2 plain lane0", 34, 32'hF0F0_1234, 32'd7, 0);
        issue("R2 plain lane63", 34, 32'hF0F0_1234, 32'd7, 63);
        issue("R2 plain zero", 34, 32'h0, 32'd100, 20);
        go_idle();
    endtask

    task automatic t_low();
        issue("R3 low lane0", 35, 32'hFFFF_FFFF, 32'd5, 0);
        issue("R3 low lane1", 35, 32'h0000_0001, 32'd0, 1);
        issue("R3 low lane17", 35, 32'hA5A5_A5A5, 32'd3, 17);
        issue("R3 low lane31", 35, 32'hFFFF_FFFF, 32'd0, 31);
        issue("R4 low lane32", 35, 32'hFFFF_FFFF, 32'd0, 32);
        issue("R4 low lane50", 35, 32'h8000_0001, 32'd10, 50);
        go_idle();
    endtask

    task automatic t_high();
        issue("R5 high lane32", 36, 32'hFFFF_FFFF, 32'd9, 32);
        issue("R5 high lane45", 36, 32'h1234_5678, 32'd1, 45);
        issue("R5 high lane63", 36, 32'hFFFF_FFFF, 32'd0, 63);
        issue("R6 high lane31", 36, 32'hFFFF_FFFF, 32'h55, 31);
        issue("R6 high lane0", 36, 32'hDEAD_BEEF, 32'hCAFE, 0);
        go_idle();
    endtask

    task automatic t_ext();
        issue("R7 ext plain", 290, 32'h0F0F_0F0F, 32'd2, 9);
        issue("R7 ext low", 291, 32'h0F0F_0F0F, 32'd2, 9);
        issue("R7 ext high", 292, 32'h0F0F_0F0F, 32'd2, 41);
        go_idle();
    endtask

    task automatic t_wrap();
        issue("R8 wrap plain", 34, 32'h0000_0003, 32'hFFFF_FFFF, 0);
        issue("R8 wrap low", 35, 32'hFFFF_FFFF, 32'hFFFF_FFF0, 40);
        go_idle();
    endtask

    task automatic t_illegal_mix();
        issue("R10 bad 33", 33, 32'hFFFF_FFFF, 32'd4, 10);
        issue("R10 legal after bad", 35, 32'h0000_00FF, 32'd1, 4);
        issue("R10 bad 37", 37, 32'hFFFF_FFFF, 32'd4, 10);
        issue("R10 bad 293", 293, 32'h1, 32'd4, 10);
        issue("R10 bad 0", 0, 32'h1, 32'd4, 10);
        go_idle();
        @(posedge clk);
        #2;
        chk("R10 illegal drops", 32'(out_illegal), 32'd0);
        chk("R9 valid drops", 32'(out_valid), 32'd0);
    endtask

    task automatic t_hold();
        logic [31:0] held;
        issue("R11 setup", 34, 32'h0000_00FF, 32'd1000, 3);
        held = model(34, 32'h0000_00FF, 32'd1000, 3);
        go_idle();
        in_opcode = 9'd35;
        in_src_a  = 32'hFFFF_FFFF;
        in_src_b  = 32'h1111_1111;
        in_lane   = 6'd60;
        repeat (3) @(posedge clk);
        #2;
        chk("R11 result held", out_result, held);
        chk("R9 no valid idle", 32'(out_valid), 32'd0);
    endtask

    task automatic t_chain();
        logic [63:0] m = 64'hF00D_1234_8421_ABCD;
        int lanes[4] = '{0, 13, 40, 63};
        foreach (lanes[j]) begin
            int exp_n = 0;
            logic [31:0] part;
            for (int k = 0; k < 64; k++) if (k < lanes[j]) exp_n += m[k];
            issue("R12 chain low", 35, m[31:0], 32'd0, lanes[j]);
            part = out_result;
            issue("R12 chain high", 36, m[63:32], part, lanes[j]);
            chk("R12 prefix total", out_result, 32'(exp_n));
        end
        go_idle();
    endtask

    initial begin
        #(CLK_PER * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_plain();
        t_low();
        t_high();
        t_ext();
        t_wrap();
        t_illegal_mix();
        t_hold();
        t_chain();
        repeat (2) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule